// File: doc/BRIEF.md
# Address-Register Pipeline Interlock Unit

This block finds register hazards between neighbouring instructions in a four-stage in-order pipeline (fetch, decode, read, execute). In this pipeline, decode computes operand addresses from a group of address registers. Each cycle the unit receives a descriptor for the instruction now in decode. The descriptor carries the register groups that instruction writes, the groups it explicitly reads, whether its write is a load-class write, and the groups its address generation uses.

The unit keeps the descriptor of the instruction that advanced into the read stage. It compares that producer with the decode consumer. Hazards are found at the level of register groups, not single registers:

- A load-class write to a group that decode needs holds decode for two cycles.
- An explicit read of a group that decode needs holds decode for one cycle.
- Reads of the index, block-size and data-page groups are exempt and never cause a hold.

For every held cycle the unit asks the fetch stage to refetch the same word, and it inserts a bubble into the read stage.

Group masks use one bit per group:

| Bit | Group |
|-----|-------|
| 0 | address registers |
| 1 | index registers |
| 2 | block size |
| 3 | data page |
| 4 | stack pointer |
| 5 | all other tracked registers |

Top module: `addr_reg_interlock`

## Requirements
- R1: After a synchronous active-high reset, `dec_hold`, `fetch_refetch` and `rd_nop_insert` are low, and no earlier instruction can cause a hold.
- R2: If an instruction with `dec_wr_load`=1 advances out of decode, and the next valid decode instruction's `dec_use_mask` shares a set bit with its `dec_wr_mask`, then decode is held for exactly two cycles. A match on the group is enough; which register inside the group is involved does not matter.
- R3: A write mask presented with `dec_wr_load`=0 (for example a pointer update during address generation) never causes a hold.
- R4: An explicit read (`dec_rd_mask`) of bit 0, 4 or 5 by the producer, matched by a set bit of the next instruction's `dec_use_mask`, holds decode for exactly one cycle.
- R5: Reads of bits 1, 2 and 3 (index, block size, data page) never cause a hold.
- R6: A producer's own address-generation use (`dec_use_mask`) is not treated as a read and causes no hold in the following instruction.
- R7: When a write conflict and a read conflict are found together, the hold lasts the longer of the two, which is two cycles.
- R8: `fetch_refetch` and `rd_nop_insert` are high in exactly the cycles in which `dec_hold` is high. After each held cycle the read stage holds a bubble.
- R9: An invalid slot never causes a hold: neither a producer that was invalid (`dec_valid`=0), nor a consumer with `dec_valid`=0.
- R10: When a hold ends, the held instruction moves into the read stage exactly once and becomes the producer for the next instruction.
- R11: Masks that share no group bit cause no hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_use_mask | input | NG | Groups decode needs for address generation |
| dec_wr_load | input | 1 | Decode instruction's write is a load-class write |
| dec_wr_mask | input | NG | Groups the decode instruction writes |
| dec_rd_mask | input | NG | Groups the decode instruction explicitly reads |
| dec_hold | output | 1 | Decode is held this cycle |
| fetch_refetch | output | 1 | Fetch stage must fetch the same word again |
| rd_nop_insert | output | 1 | A bubble enters the read stage |

## Verification
Producer and consumer pairs are issued back to back. The pairs cover:

- a load-class write against an address-generation use, which must give two held cycles;
- the same write mask without the load flag, which must give none;
- explicit reads of each exempt group and of the stack-pointer and address groups, which tell the one-cycle rule apart from the exemption list;
- a combined write-and-read producer, which shows that the longer hold wins.

Invalid producer and consumer slots, and groups that do not overlap, must show no hold. A chain of three dependent instructions shows that a released instruction becomes the next producer exactly once. Every held cycle is also checked for the refetch and bubble outputs.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
   localparam int GRP_AUX   = 0;
   localparam int GRP_IDX   = 1;
   localparam int GRP_BLK   = 2;
   localparam int GRP_PAGE  = 3;
   localparam int GRP_SP    = 4;
   localparam int GRP_OTHER = 5;
   localparam int GRP_COUNT = 6;

   function automatic logic [GRP_COUNT-1:0] default_exempt();
      logic [GRP_COUNT-1:0] m;
      m = '0;
      m[GRP_IDX]  = 1'b1;
      m[GRP_BLK]  = 1'b1;
      m[GRP_PAGE] = 1'b1;
      return m;
   endfunction

   function automatic int stall_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ilk_slot.sv
module ilk_slot #(
   parameter int NG = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic          in_load,
   input  logic [NG-1:0] in_wr,
   input  logic [NG-1:0] in_rd,
   output logic          q_vld,
   output logic          q_load,
   output logic [NG-1:0] q_wr,
   output logic [NG-1:0] q_rd
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_vld  <= 1'b0;
         q_load <= 1'b0;
         q_wr   <= '0;
         q_rd   <= '0;
      end else if (adv) begin
         q_vld  <= 1'b1;
         q_load <= in_load;
         q_wr   <= in_wr;
         q_rd   <= in_rd;
      end else begin
         q_vld  <= 1'b0;
         q_load <= 1'b0;
         q_wr   <= '0;
         q_rd   <= '0;
      end
   end
endmodule

// File: rtl/ilk_detect.sv
module ilk_detect #(
   parameter int          NG     = 6,
   parameter logic [NG-1:0] EXEMPT = '0,
   parameter bit          RD_EN  = 1'b1
) (
   input  logic          p_vld,
   input  logic          p_load,
   input  logic [NG-1:0] p_wr,
   input  logic [NG-1:0] p_rd,
   input  logic          c_vld,
   input  logic [NG-1:0] c_use,
   output logic          wr_hit,
   output logic          rd_hit
);
   logic [NG-1:0] wr_terms;
   logic [NG-1:0] rd_terms;

   for (genvar g = 0; g < NG; g++) begin : g_grp
      assign wr_terms[g] = p_wr[g] & c_use[g];
      if (EXEMPT[g] || !RD_EN) begin : g_exempt
         assign rd_terms[g] = 1'b0;
      end else begin : g_track
         assign rd_terms[g] = p_rd[g] & c_use[g];
      end
   end

   always_comb begin
      wr_hit = p_vld & c_vld & p_load & (|wr_terms);
      rd_hit = p_vld & c_vld & (|rd_terms);
   end
endmodule

// File: rtl/ilk_counter.sv
module ilk_counter #(
   parameter int WR_STALL = 2,
   parameter int RD_STALL = 1,
   parameter int CW       = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic wr_hit,
   input  logic rd_hit,
   output logic hold
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] need;
   logic [CW-1:0] need_wr;
   logic [CW-1:0] need_rd;
   logic          idle;

   always_comb begin
      idle    = (cnt_q == '0);
      need_wr = wr_hit ? CW'(WR_STALL) : '0;
      need_rd = rd_hit ? CW'(RD_STALL) : '0;
      need    = (need_wr > need_rd) ? need_wr : need_rd;
      if (!idle) need = '0;
      hold    = !idle || (need != '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (!idle) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (need != '0) begin
         cnt_q <= need - 1'b1;
      end
   end
endmodule

// File: rtl/addr_reg_interlock.sv
module addr_reg_interlock
   import ilk_pkg::*;
#(
   parameter int              NG       = GRP_COUNT,
   parameter int              WR_STALL = 2,
   parameter int              RD_STALL = 1,
   parameter logic [NG-1:0]   EXEMPT   = NG'(default_exempt())
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          dec_valid,
   input  logic [NG-1:0] dec_use_mask,
   input  logic          dec_wr_load,
   input  logic [NG-1:0] dec_wr_mask,
   input  logic [NG-1:0] dec_rd_mask,
   output logic          dec_hold,
   output logic          fetch_refetch,
   output logic          rd_nop_insert
);
   localparam int MAXS = stall_max(WR_STALL, RD_STALL);
   localparam int CW   = (MAXS < 2) ? 1 : $clog2(MAXS + 1);
   localparam bit RDEN = (RD_STALL > 0);

   initial begin
      if (NG < GRP_COUNT) $error("NG must cover all named groups");
      if (WR_STALL < 1)   $error("WR_STALL must be at least 1");
      if (RD_STALL < 0)   $error("RD_STALL must not be negative");
   end

   logic          adv;
   logic          slot_vld;
   logic          slot_load;
   logic [NG-1:0] slot_wr;
   logic [NG-1:0] slot_rd;
   logic          wr_hit;
   logic          rd_hit;
   logic          hold_i;

   assign adv = dec_valid && !hold_i;

   ilk_slot #(.NG(NG)) u_slot (
      .clk(clk), .rst(rst), .adv(adv),
      .in_load(dec_wr_load), .in_wr(dec_wr_mask), .in_rd(dec_rd_mask),
      .q_vld(slot_vld), .q_load(slot_load), .q_wr(slot_wr), .q_rd(slot_rd)
   );

   ilk_detect #(.NG(NG), .EXEMPT(EXEMPT), .RD_EN(RDEN)) u_det (
      .p_vld(slot_vld), .p_load(slot_load), .p_wr(slot_wr), .p_rd(slot_rd),
      .c_vld(dec_valid), .c_use(dec_use_mask),
      .wr_hit(wr_hit), .rd_hit(rd_hit)
   );

   ilk_counter #(.WR_STALL(WR_STALL), .RD_STALL(RD_STALL), .CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .wr_hit(wr_hit), .rd_hit(rd_hit), .hold(hold_i)
   );

   assign dec_hold      = hold_i;
   assign fetch_refetch = hold_i;
   assign rd_nop_insert = hold_i;
endmodule

// File: rtl/ilk_chk.sv
module ilk_chk #(
   parameter int            NG       = 6,
   parameter int            WR_STALL = 2,
   parameter int            RD_STALL = 1,
   parameter logic [NG-1:0] EXEMPT   = '0
) (
   input logic          clk,
   input logic          rst,
   input logic          dec_valid,
   input logic [NG-1:0] dec_use_mask,
   input logic          dec_wr_load,
   input logic [NG-1:0] dec_wr_mask,
   input logic [NG-1:0] dec_rd_mask,
   input logic          dec_hold,
   input logic          slot_vld
);
   localparam int MAXS = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL;

   logic          p_adv, p_load, p_hold;
   logic [NG-1:0] p_wr, p_rd;
   logic [7:0]    run;
   logic          wr_c, rd_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         p_adv <= 1'b0; p_load <= 1'b0; p_hold <= 1'b0;
         p_wr <= '0; p_rd <= '0; run <= '0;
      end else begin
         p_adv  <= dec_valid && !dec_hold;
         p_load <= dec_wr_load;
         p_hold <= dec_hold;
         p_wr   <= dec_wr_mask;
         p_rd   <= dec_rd_mask;
         run    <= dec_hold ? ((run == 8'hFF) ? run : run + 8'd1) : 8'd0;
      end
   end

   assign wr_c = p_adv && dec_valid && p_load && |(dec_use_mask & p_wr);
   assign rd_c = p_adv && dec_valid && |(dec_use_mask & p_rd & ~EXEMPT);

   AST_WR_FIRST: assert property (@(posedge clk) disable iff (rst)
      wr_c |-> dec_hold);                                   // R2
   if (WR_STALL >= 2) begin : g_wr2
      AST_WR_SECOND: assert property (@(posedge clk) disable iff (rst)
         wr_c |=> dec_hold);                                // R2
   end
   if (RD_STALL >= 1) begin : g_rd
      AST_RD_DELAY: assert property (@(posedge clk) disable iff (rst)
         rd_c |-> dec_hold);                                // R4
   end
   AST_NO_FALSE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!p_hold && !wr_c && !rd_c) |-> !dec_hold);           // R5
   AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!dec_valid && !p_hold) |-> !dec_hold);               // R9
   AST_BUBBLE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
      p_hold |-> !slot_vld);                                // R8
   AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
      run <= 8'(MAXS));                                     // R7
endmodule

bind addr_reg_interlock ilk_chk #(
   .NG(NG), .WR_STALL(WR_STALL), .RD_STALL(RD_STALL), .EXEMPT(EXEMPT)
) u_chk (
   .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_use_mask(dec_use_mask),
   .dec_wr_load(dec_wr_load), .dec_wr_mask(dec_wr_mask),
   .dec_rd_mask(dec_rd_mask), .dec_hold(dec_hold), .slot_vld(slot_vld)
);

// File: tb/sim_addr_reg_interlock.sv
module sim_addr_reg_interlock;
   localparam int NG = 6;
   localparam logic [5:0] AUX = 6'b000001, IDX = 6'b000010, BLK = 6'b000100,
                          PAGE = 6'b001000, SP = 6'b010000, OTH = 6'b100000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          dec_valid = 1'b0;
   logic [NG-1:0] dec_use_mask = '0;
   logic          dec_wr_load = 1'b0;
   logic [NG-1:0] dec_wr_mask = '0;
   logic [NG-1:0] dec_rd_mask = '0;
   logic          dec_hold, fetch_refetch, rd_nop_insert;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   addr_reg_interlock u0 (
      .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_use_mask(dec_use_mask),
      .dec_wr_load(dec_wr_load), .dec_wr_mask(dec_wr_mask),
      .dec_rd_mask(dec_rd_mask), .dec_hold(dec_hold),
      .fetch_refetch(fetch_refetch), .rd_nop_insert(rd_nop_insert)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Presents one instruction in decode; returns the number of held cycles.
   task automatic issue(input logic v, input logic [5:0] use_m, input logic ld,
                        input logic [5:0] wr, input logic [5:0] rd,
                        output int held);
      @(negedge clk);
      dec_valid = v; dec_use_mask = use_m; dec_wr_load = ld;
      dec_wr_mask = wr; dec_rd_mask = rd;
      #1;
      held = 0;
      while (dec_hold && held < 8) begin
         check("R8 refetch", int'(fetch_refetch), 1);
         check("R8 nop", int'(rd_nop_insert), 1);
         held++;
         @(negedge clk);
         #1;
      end
      check("R8 refetch off", int'(fetch_refetch), 0);
      check("R8 nop off", int'(rd_nop_insert), 0);
   endtask

   task automatic idle();
      int h;
      issue(1'b0, '0, 1'b0, '0, '0, h);
   endtask

   task automatic pair(input string req, input logic pv, input logic [5:0] pu,
                       input logic pl, input logic [5:0] pw, input logic [5:0] pr,
                       input logic cv, input logic [5:0] cu, input int exp);
      int h;
      idle();
      issue(pv, pu, pl, pw, pr, h);
      check({req, " producer"}, h, 0);
      issue(cv, cu, 1'b0, '0, '0, h);
      check(req, h, exp);
      idle();
   endtask

   task automatic t_reset();
      #1;
      check("R1 hold", int'(dec_hold), 0);
      check("R1 refetch", int'(fetch_refetch), 0);
      check("R1 nop", int'(rd_nop_insert), 0);
   endtask

   task automatic t_chain();
      int h;
      idle();
      issue(1'b1, '0, 1'b1, AUX, '0, h);
      check("R10 first", h, 0);
      issue(1'b1, AUX, 1'b1, AUX, '0, h);
      check("R10 second stall", h, 2);
      issue(1'b1, AUX, 1'b0, '0, '0, h);
      check("R10 third stall", h, 2);
      issue(1'b1, AUX, 1'b0, '0, '0, h);
      check("R10 no repeat", h, 0);
      idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      pair("R2 load aux", 1'b1, '0, 1'b1, AUX, '0, 1'b1, AUX, 2);
      pair("R2 load sp", 1'b1, '0, 1'b1, SP, '0, 1'b1, SP | AUX, 2);
      pair("R3 non-load write", 1'b1, '0, 1'b0, AUX, '0, 1'b1, AUX, 0);
      pair("R4 read sp", 1'b1, '0, 1'b0, '0, SP, 1'b1, SP, 1);
      pair("R4 read aux", 1'b1, '0, 1'b0, '0, AUX, 1'b1, AUX, 1);
      pair("R4 read other", 1'b1, '0, 1'b0, '0, OTH, 1'b1, OTH, 1);
      pair("R5 read idx", 1'b1, '0, 1'b0, '0, IDX, 1'b1, IDX, 0);
      pair("R5 read blk", 1'b1, '0, 1'b0, '0, BLK, 1'b1, BLK, 0);
      pair("R5 read page", 1'b1, '0, 1'b0, '0, PAGE, 1'b1, PAGE | AUX, 0);
      pair("R6 agen not read", 1'b1, AUX, 1'b0, '0, '0, 1'b1, AUX, 0);
      pair("R7 both conflicts", 1'b1, '0, 1'b1, AUX, SP, 1'b1, AUX | SP, 2);
      pair("R9 invalid producer", 1'b0, '0, 1'b1, AUX, SP, 1'b1, AUX | SP, 0);
      pair("R9 invalid consumer", 1'b1, '0, 1'b1, AUX, '0, 1'b0, AUX, 0);
      pair("R11 disjoint groups", 1'b1, '0, 1'b1, IDX, SP, 1'b1, AUX, 0);
      t_chain();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule